// File: doc/BRIEF.md
# Burst Address Sequencer With Dual Strobes

This block produces the word address for a four-beat burst. A start address is loaded when either of two active-low address strobes is sampled low on a rising clock edge. After that, each cycle in which the active-low advance input is low, and no strobe is active, moves the two low address bits to the next beat of the burst. The upper address bits stay as they were captured. The two low bits wrap inside the aligned four-word block.

The two strobes have a fixed priority. The processor strobe wins over the controller strobe. The processor strobe only counts while the primary select is low; the controller strobe is not gated by the select. The visiting order comes from a static order pin. In linear order the start value is incremented modulo four. In interleaved order the start value is XORed with the beat number. Interleaved order is the default strap value. All of these are plain control pins, so there is no valid/ready handshake and no back-pressure: a load or a step takes effect at the sampling edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the reset overrides every other input and both `addr_q` and `burst_addr` become zero.
- R2: When `proc_stb_n` is low and `sel_n` is low at an edge, `addr_q` takes `addr_in`, and `burst_addr` equals `addr_in` after that edge, with its beat number at zero.
- R3: When `proc_stb_n` is low, `sel_n` is high and `ctrl_stb_n` is high, no load happens. With `adv_n` high, both outputs keep their values.
- R4: When `ctrl_stb_n` is low, a load as in R2 happens whatever the level of `sel_n`.
- R5: When both strobes are low and `sel_n` is low, exactly one load of `addr_in` happens, and the beat number restarts at zero.
- R6: With `order_ilv` = 0 (linear), each advance makes `burst_addr[1:0]` equal to (start + beats advanced) mod 4.
- R7: With `order_ilv` = 1 (interleaved), each advance makes `burst_addr[1:0]` equal to start XOR beats advanced, where the beat count is taken mod 4.
- R8: With no strobe active and `adv_n` high, `burst_addr` holds its value.
- R9: `burst_addr[ADDR_W-1:2]` always equals `addr_q[ADDR_W-1:2]`, and `addr_q` never changes during a burst.
- R10: A strobe load takes priority over a simultaneous advance. The output then shows the new start address.
- R11: After four advances the low bits return to the start value, in both orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| proc_stb_n | input | 1 | Processor address strobe, active low, gated by `sel_n` |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Primary select, active low |
| addr_in | input | ADDR_W | Incoming word address |
| order_ilv | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| addr_q | output | ADDR_W | Registered start address |
| burst_addr | output | ADDR_W | Current burst word address |

## Verification
The checker watches the following on every cycle:
- a gated or ungated strobe load captures the sampled address and restarts the beat;
- an idle cycle with no advance leaves the captured address and the burst address unchanged;
- each linear step adds one to the low bits;
- each interleaved step changes the low bits;
- the upper bits of the burst address track the captured address.

Only the bench's scenarios can show the rest:
- the full interleaved sequence for a given start value;
- the wrap back to the start after four beats;
- a load that wins over an advance in the same cycle;
- the reset overriding a strobe that is asserted at the same time.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bseq_strobe_arb.sv
module bseq_strobe_arb (
  input  logic proc_stb_n,
  input  logic ctrl_stb_n,
  input  logic sel_n,
  output logic load_o
);
  logic proc_take;
  logic ctrl_take;

  // processor strobe counts only while the primary select is active
  always_comb begin
    proc_take = ~proc_stb_n & ~sel_n;
    // controller strobe is considered only when the processor does not win
    ctrl_take = ~ctrl_stb_n & ~proc_take;
    load_o    = proc_take | ctrl_take;
  end
endmodule

// File: rtl/bseq_addr_reg.sv
module bseq_addr_reg #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
  import bseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  step,
  input  logic  order_ilv,
  input  beat_t start_in,
  output beat_t lo_out
);
  beat_t start_q;
  beat_t beat_q;
  beat_t lin_lo;
  beat_t ilv_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      start_q <= start_in;
      beat_q  <= '0;
    end else if (step) begin
      beat_q  <= beat_q + beat_t'(1);
    end
  end

  assign lin_lo = start_q + beat_q;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_lo[b] = start_q[b] ^ beat_q[b];
  end

  always_comb begin
    unique case (order_e'(order_ilv))
      ORD_INTERLEAVE: lo_out = ilv_lo;
      default:        lo_out = lin_lo;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              adv_n,
  input  logic              sel_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] burst_addr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic  load;
  logic  step;
  beat_t lo;

  bseq_strobe_arb u_arb (
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .sel_n      (sel_n),
    .load_o     (load)
  );

  assign step = ~load & ~adv_n;

  bseq_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .d    (addr_in),
    .q    (addr_q)
  );

  bseq_beat_ctr u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .order_ilv (order_ilv),
    .start_in  (addr_in[BEAT_W-1:0]),
    .lo_out    (lo)
  );

  assign burst_addr = {addr_q[ADDR_W-1 -: UPPER_W], lo};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              proc_stb_n,
  input logic              ctrl_stb_n,
  input logic              adv_n,
  input logic              sel_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              order_ilv,
  input logic [ADDR_W-1:0] addr_q,
  input logic [ADDR_W-1:0] burst_addr
);
  logic any_load;
  assign any_load = (~proc_stb_n & ~sel_n) | ~ctrl_stb_n;

  p_load_proc_r2: assert property (@(posedge clk) disable iff (rst)
    (!proc_stb_n && !sel_n) |=> (addr_q == $past(addr_in)) && (burst_addr == $past(addr_in)));

  p_gated_proc_r3: assert property (@(posedge clk) disable iff (rst)
    (!proc_stb_n && sel_n && ctrl_stb_n) |=> $stable(addr_q));

  p_load_ctrl_r4: assert property (@(posedge clk) disable iff (rst)
    !ctrl_stb_n |=> (addr_q == $past(addr_in)) && (burst_addr == $past(addr_in)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!any_load && adv_n) |=> $stable(burst_addr) && $stable(addr_q));

  p_linear_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!any_load && !adv_n && !order_ilv && $stable(order_ilv))
      |=> (burst_addr[1:0] == $past(burst_addr[1:0]) + 2'd1) || $changed(order_ilv));

  p_ilv_step_r7: assert property (@(posedge clk) disable iff (rst)
    (!any_load && !adv_n && order_ilv)
      |=> ($countones(burst_addr[1:0] ^ $past(burst_addr[1:0])) != 0) || $changed(order_ilv));

  p_upper_fixed_r9: assert property (@(posedge clk) disable iff (rst)
    !any_load |=> $stable(burst_addr[ADDR_W-1:2]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .proc_stb_n (proc_stb_n),
  .ctrl_stb_n (ctrl_stb_n),
  .adv_n      (adv_n),
  .sel_n      (sel_n),
  .addr_in    (addr_in),
  .order_ilv  (order_ilv),
  .addr_q     (addr_q),
  .burst_addr (burst_addr)
);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst;
  logic          proc_stb_n, ctrl_stb_n, adv_n, sel_n, order_ilv;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_q, burst_addr;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
    .clk(clk), .rst(rst), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
    .adv_n(adv_n), .sel_n(sel_n), .addr_in(addr_in), .order_ilv(order_ilv),
    .addr_q(addr_q), .burst_addr(burst_addr)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic p, input logic c, input logic a, input logic s,
                       input logic [AW-1:0] ad);
    proc_stb_n = p; ctrl_stb_n = c; adv_n = a; sel_n = s; addr_in = ad;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 17'h0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 17'h1FFFF);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 17'h15555);
    check("R1 addr_q", addr_q, '0);
    check("R1 burst_addr", burst_addr, '0);
    rst = 1'b0;
    idle();
  endtask

  task automatic t_proc_load();
    drive(1'b0, 1'b1, 1'b1, 1'b0, 17'h1ABC6);
    check("R2 addr_q", addr_q, 17'h1ABC6);
    check("R2 burst_addr", burst_addr, 17'h1ABC6);
  endtask

  task automatic t_proc_gated();
    drive(1'b0, 1'b1, 1'b1, 1'b1, 17'h00F01);
    check("R3 addr_q", addr_q, 17'h1ABC6);
    check("R3 burst_addr", burst_addr, 17'h1ABC6);
  endtask

  task automatic t_ctrl_load();
    drive(1'b1, 1'b0, 1'b1, 1'b1, 17'h0A5A9);
    check("R4 addr_q sel high", addr_q, 17'h0A5A9);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 17'h13332);
    check("R4 burst_addr sel low", burst_addr, 17'h13332);
  endtask

  task automatic t_both();
    drive(1'b1, 1'b1, 1'b0, 1'b1, 17'h0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 17'h04441);
    check("R5 addr_q", addr_q, 17'h04441);
    check("R5 beat restart", burst_addr, 17'h04441);
  endtask

  task automatic t_burst(input logic ilv, input logic [AW-1:0] base, input string rq);
    order_ilv = ilv;
    drive(1'b1, 1'b0, 1'b1, 1'b1, base);
    for (int n = 1; n <= 4; n++) begin
      logic [1:0] s;
      logic [1:0] e;
      drive(1'b1, 1'b1, 1'b0, 1'b1, 17'h0);
      s = base[1:0];
      e = ilv ? (s ^ 2'(n)) : (s + 2'(n));
      check(n == 4 ? "R11 wrap" : rq, burst_addr, {base[AW-1:2], e});
      check("R9 upper fixed", addr_q, base);
    end
  endtask

  task automatic t_hold();
    order_ilv = 1'b0;
    drive(1'b1, 1'b0, 1'b1, 1'b1, 17'h1F002);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 17'h0);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 17'h0ABCD);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 17'h0ABCD);
    check("R8 hold", burst_addr, 17'h1F003);
  endtask

  task automatic t_override();
    order_ilv = 1'b1;
    drive(1'b1, 1'b0, 1'b1, 1'b1, 17'h02221);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 17'h0);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 17'h07772);
    check("R10 load wins", burst_addr, 17'h07772);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 17'h0);
    check("R10 first step", burst_addr, 17'h07773);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    order_ilv = 1'b1;
    rst = 1'b1;
    proc_stb_n = 1'b1; ctrl_stb_n = 1'b1; adv_n = 1'b1; sel_n = 1'b1; addr_in = '0;
    @(negedge clk);
    t_reset();
    t_proc_load();
    t_proc_gated();
    t_ctrl_load();
    t_both();
    t_burst(1'b0, 17'h12343, "R6 linear");
    t_burst(1'b1, 17'h05671, "R7 interleaved");
    t_burst(1'b1, 17'h08882, "R7 interleaved");
    t_hold();
    t_override();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule